// File: doc/BRIEF.md
# Tournament Local/Global Branch Direction Predictor

This block predicts the direction of conditional branches. Two predictors run side by side. The local predictor keeps a short outcome history for each branch slot, picked by the low bits of the branch address. That history then selects one of a table of three-bit saturating counters. The global predictor uses a register holding the most recent outcomes of all branches to select a two-bit saturating counter. A chooser table, indexed by the same global history, records whether each predictor was right the last time that entry was used. It picks the local result only when local alone was right.

A front end presents a branch address on the lookup port. One cycle later the block returns the final taken bit, together with the local counter index, the global index and both component predictions. The pipeline carries these four values with the branch. When the branch resolves, it returns them on the resolution port along with the branch address and the actual outcome. Resolutions arrive in program order. Histories change only at resolution and are never updated speculatively.

Top module: `tg_dir_pred`

## Requirements
- R1: After reset, every two-bit counter holds 2'b10, every three-bit counter holds 3'b100, every history is zero and every chooser entry is 2'b00, so a first lookup returns taken=1, both component predictions 1, local index 0 and global index 0.
- R2: Lookup outputs are registered: they reflect the address presented in the cycle lk_valid_i was high and appear after the next rising edge; while lk_valid_i is low they hold their previous values.
- R3: The local index returned for address pc equals the history of slot pc[SLOT_W-1:0]; each resolution shifts its outcome into bit 0 of that slot's history (1 = taken), discarding the oldest bit.
- R4: Local counters are three bits wide, increment on taken and decrement on not-taken, saturate at 3'b111 and 3'b000, and predict taken when bit 2 is 1.
- R5: The global index equals the global history register, into whose bit 0 every resolution shifts its outcome.
- R6: Global counters are two bits wide (00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken), step up on taken and down on not-taken with saturation, and predict taken when bit 1 is 1.
- R7: A resolution rewrites the chooser entry at the returned global index to {global prediction == outcome, local prediction == outcome}.
- R8: The final prediction equals the local prediction only when the chooser entry read at lookup is 2'b01 (global wrong, local right); otherwise it equals the global prediction.
- R9: While rs_valid_i is low, the resolution inputs change no history, counter or chooser entry.
- R10: A lookup in the same cycle as a resolution reads the state as it was before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W | Branch address to look up |
| lk_taken_o | output | 1 | Final taken prediction |
| lk_loc_idx_o | output | LHIST_W | Local counter index used |
| lk_glb_idx_o | output | GHIST_W | Global history used as index |
| lk_loc_pred_o | output | 1 | Local component prediction |
| lk_glb_pred_o | output | 1 | Global component prediction |
| rs_valid_i | input | 1 | Resolution strobe |
| rs_pc_i | input | PC_W | Address of the resolved branch |
| rs_taken_i | input | 1 | Actual outcome, 1 = taken |
| rs_loc_idx_i | input | LHIST_W | Local index returned at lookup |
| rs_glb_idx_i | input | GHIST_W | Global index returned at lookup |
| rs_loc_pred_i | input | 1 | Local prediction returned at lookup |
| rs_glb_pred_i | input | 1 | Global prediction returned at lookup |

## Verification
The bench drives counters past both ends. A wrapping counter would flip its prediction after four steps up or five steps down. It fills chooser entries with the global-wrong/local-right pattern and with the both-right pattern, then steers the history back to each entry. A selector that used the wrong bit, or treated the entry as a counter, would return the wrong component. It also presents a lookup in the same edge as a resolution, which catches a bypass that leaks new state into the lookup. It drives resolution fields with the strobe low, which exposes any write that ignores the strobe. A long address-mixed run compared against an independent model catches misplaced history bits or counter indices.

// File: rtl/tg_pred_pkg.sv
package tg_pred_pkg;
  // saturating step for counters up to 8 bits wide
  function automatic logic [7:0] sat_step(input logic [7:0] cnt, input logic up,
                                          input int unsigned w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    if (up) return (cnt == top) ? cnt : cnt + 8'd1;
    else    return (cnt == 8'd0) ? cnt : cnt - 8'd1;
  endfunction
endpackage

// File: rtl/tg_local_stage.sv
module tg_local_stage #(
  parameter int PC_W    = 16,
  parameter int SLOT_W  = 8,
  parameter int LHIST_W = 8,
  parameter int LCTR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    lk_pc_i,
  output logic [LHIST_W-1:0] lk_idx_o,
  output logic               lk_pred_o,
  input  logic               rs_valid_i,
  input  logic [PC_W-1:0]    rs_pc_i,
  input  logic               rs_taken_i,
  input  logic [LHIST_W-1:0] rs_idx_i
);
  import tg_pred_pkg::*;
  localparam int SLOTS = 1 << SLOT_W;
  localparam int CTRS  = 1 << LHIST_W;
  localparam logic [LCTR_W-1:0] CTR_INIT = LCTR_W'(1 << (LCTR_W - 1));
  localparam logic [LCTR_W-1:0] CTR_MAX  = {LCTR_W{1'b1}};

  logic [LHIST_W-1:0] hist_q [SLOTS];
  logic [LCTR_W-1:0]  ctr_q  [CTRS];
  logic [SLOT_W-1:0]  lk_slot, rs_slot;

  assign lk_slot   = lk_pc_i[SLOT_W-1:0];
  assign rs_slot   = rs_pc_i[SLOT_W-1:0];
  assign lk_idx_o  = hist_q[lk_slot];
  assign lk_pred_o = ctr_q[lk_idx_o][LCTR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) hist_q[i] <= '0;
    end else if (rs_valid_i) begin
      hist_q[rs_slot] <= {hist_q[rs_slot][LHIST_W-2:0], rs_taken_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CTRS; i++) ctr_q[i] <= CTR_INIT;
    end else if (rs_valid_i) begin
      ctr_q[rs_idx_i] <= LCTR_W'(sat_step(8'(ctr_q[rs_idx_i]), rs_taken_i, LCTR_W));
    end
  end

  AST_LCTR_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i && rs_taken_i && ctr_q[rs_idx_i] == CTR_MAX |=> ctr_q[$past(rs_idx_i)] == CTR_MAX); // R4
  AST_LCTR_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i && !rs_taken_i && ctr_q[rs_idx_i] == '0 |=> ctr_q[$past(rs_idx_i)] == '0); // R4
  AST_LHIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i |=> hist_q[$past(rs_slot)][0] == $past(rs_taken_i)); // R3
endmodule

// File: rtl/tg_global_stage.sv
module tg_global_stage #(
  parameter int GHIST_W = 10,
  parameter int GCTR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [GHIST_W-1:0] lk_idx_o,
  output logic               lk_pred_o,
  input  logic               rs_valid_i,
  input  logic               rs_taken_i,
  input  logic [GHIST_W-1:0] rs_idx_i
);
  import tg_pred_pkg::*;
  localparam int CTRS = 1 << GHIST_W;
  localparam logic [GCTR_W-1:0] CTR_INIT = GCTR_W'(1 << (GCTR_W - 1));
  localparam logic [GCTR_W-1:0] CTR_MAX  = {GCTR_W{1'b1}};

  logic [GHIST_W-1:0] ghr_q;
  logic [GCTR_W-1:0]  ctr_q [CTRS];

  assign lk_idx_o  = ghr_q;
  assign lk_pred_o = ctr_q[ghr_q][GCTR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ghr_q <= '0;
    else if (rs_valid_i) ghr_q <= {ghr_q[GHIST_W-2:0], rs_taken_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CTRS; i++) ctr_q[i] <= CTR_INIT;
    end else if (rs_valid_i) begin
      ctr_q[rs_idx_i] <= GCTR_W'(sat_step(8'(ctr_q[rs_idx_i]), rs_taken_i, GCTR_W));
    end
  end

  AST_GHR_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i |=> ghr_q == {$past(ghr_q[GHIST_W-2:0]), $past(rs_taken_i)}); // R5
  AST_GHR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_valid_i |=> $stable(ghr_q)); // R9
  AST_GCTR_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i && rs_taken_i && ctr_q[rs_idx_i] == CTR_MAX |=> ctr_q[$past(rs_idx_i)] == CTR_MAX); // R6
endmodule

// File: rtl/tg_chooser.sv
module tg_chooser #(
  parameter int GHIST_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GHIST_W-1:0] lk_idx_i,
  input  logic               lk_loc_pred_i,
  input  logic               lk_glb_pred_i,
  output logic               lk_final_o,
  input  logic               rs_valid_i,
  input  logic               rs_taken_i,
  input  logic [GHIST_W-1:0] rs_idx_i,
  input  logic               rs_loc_pred_i,
  input  logic               rs_glb_pred_i
);
  localparam int ENTRIES = 1 << GHIST_W;

  // bit 1: global was right, bit 0: local was right
  logic [1:0] sel_q [ENTRIES];
  logic [1:0] sel_rd;

  assign sel_rd     = sel_q[lk_idx_i];
  assign lk_final_o = (sel_rd == 2'b01) ? lk_loc_pred_i : lk_glb_pred_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) sel_q[i] <= 2'b00;
    end else if (rs_valid_i) begin
      sel_q[rs_idx_i] <= {rs_glb_pred_i == rs_taken_i, rs_loc_pred_i == rs_taken_i};
    end
  end

  AST_SEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i |=> sel_q[$past(rs_idx_i)] ==
      {$past(rs_glb_pred_i) == $past(rs_taken_i), $past(rs_loc_pred_i) == $past(rs_taken_i)}); // R7
endmodule

// File: rtl/tg_dir_pred.sv
module tg_dir_pred #(
  parameter int PC_W    = 16,
  parameter int SLOT_W  = 8,
  parameter int LHIST_W = 8,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 10,
  parameter int GCTR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [PC_W-1:0]    lk_pc_i,
  output logic               lk_taken_o,
  output logic [LHIST_W-1:0] lk_loc_idx_o,
  output logic [GHIST_W-1:0] lk_glb_idx_o,
  output logic               lk_loc_pred_o,
  output logic               lk_glb_pred_o,
  input  logic               rs_valid_i,
  input  logic [PC_W-1:0]    rs_pc_i,
  input  logic               rs_taken_i,
  input  logic [LHIST_W-1:0] rs_loc_idx_i,
  input  logic [GHIST_W-1:0] rs_glb_idx_i,
  input  logic               rs_loc_pred_i,
  input  logic               rs_glb_pred_i
);
  logic [LHIST_W-1:0] loc_idx;
  logic [GHIST_W-1:0] glb_idx;
  logic               loc_pred, glb_pred, final_pred;

  tg_local_stage #(.PC_W(PC_W), .SLOT_W(SLOT_W), .LHIST_W(LHIST_W), .LCTR_W(LCTR_W)) u_loc (
    .clk_i, .rst_ni,
    .lk_pc_i, .lk_idx_o(loc_idx), .lk_pred_o(loc_pred),
    .rs_valid_i, .rs_pc_i, .rs_taken_i, .rs_idx_i(rs_loc_idx_i)
  );

  tg_global_stage #(.GHIST_W(GHIST_W), .GCTR_W(GCTR_W)) u_glb (
    .clk_i, .rst_ni,
    .lk_idx_o(glb_idx), .lk_pred_o(glb_pred),
    .rs_valid_i, .rs_taken_i, .rs_idx_i(rs_glb_idx_i)
  );

  tg_chooser #(.GHIST_W(GHIST_W)) u_sel (
    .clk_i, .rst_ni,
    .lk_idx_i(glb_idx), .lk_loc_pred_i(loc_pred), .lk_glb_pred_i(glb_pred),
    .lk_final_o(final_pred),
    .rs_valid_i, .rs_taken_i, .rs_idx_i(rs_glb_idx_i),
    .rs_loc_pred_i, .rs_glb_pred_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_taken_o    <= 1'b1;
      lk_loc_idx_o  <= '0;
      lk_glb_idx_o  <= '0;
      lk_loc_pred_o <= 1'b1;
      lk_glb_pred_o <= 1'b1;
    end else if (lk_valid_i) begin
      lk_taken_o    <= final_pred;
      lk_loc_idx_o  <= loc_idx;
      lk_glb_idx_o  <= glb_idx;
      lk_loc_pred_o <= loc_pred;
      lk_glb_pred_o <= glb_pred;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> $stable(lk_taken_o) && $stable(lk_loc_idx_o) && $stable(lk_glb_idx_o)); // R2
  AST_OUT_GLB_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_glb_idx_o == $past(glb_idx)); // R5
  always_comb begin
    if (rst_ni)
      AST_FINAL_SRC: assert (lk_taken_o == lk_glb_pred_o || lk_taken_o == lk_loc_pred_o); // R8
  end
endmodule

// File: tb/tg_dir_pred_tb_top.sv
module tg_dir_pred_tb_top;
  localparam int PC_W = 16, SLOT_W = 8, LHIST_W = 8, LCTR_W = 3, GHIST_W = 10, GCTR_W = 2;
  localparam int SLOTS = 1 << SLOT_W, LCTRS = 1 << LHIST_W, GCTRS = 1 << GHIST_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, rs_valid = 1'b0, rs_taken = 1'b0, rs_lp = 1'b0, rs_gp = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
  logic [LHIST_W-1:0] rs_li = '0;
  logic [GHIST_W-1:0] rs_gi = '0;
  logic lk_taken, lk_lp, lk_gp;
  logic [LHIST_W-1:0] lk_li;
  logic [GHIST_W-1:0] lk_gi;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // independent model
  logic [LHIST_W-1:0] m_hist [SLOTS];
  int                 m_lctr [LCTRS];
  int                 m_gctr [GCTRS];
  logic [1:0]         m_sel  [GCTRS];
  logic [GHIST_W-1:0] m_ghr;

  always #5 clk = ~clk;

  tg_dir_pred #(.PC_W(PC_W), .SLOT_W(SLOT_W), .LHIST_W(LHIST_W), .LCTR_W(LCTR_W),
                .GHIST_W(GHIST_W), .GCTR_W(GCTR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc), .lk_taken_o(lk_taken),
    .lk_loc_idx_o(lk_li), .lk_glb_idx_o(lk_gi), .lk_loc_pred_o(lk_lp), .lk_glb_pred_o(lk_gp),
    .rs_valid_i(rs_valid), .rs_pc_i(rs_pc), .rs_taken_i(rs_taken),
    .rs_loc_idx_i(rs_li), .rs_glb_idx_i(rs_gi), .rs_loc_pred_i(rs_lp), .rs_glb_pred_i(rs_gp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < SLOTS; i++) m_hist[i] = '0;
    for (int i = 0; i < LCTRS; i++) m_lctr[i] = 4;
    for (int i = 0; i < GCTRS; i++) begin m_gctr[i] = 2; m_sel[i] = 2'b00; end
    m_ghr = '0;
  endtask

  task automatic m_resolve(input logic [PC_W-1:0] pc, input logic t, input logic [LHIST_W-1:0] li,
                           input logic [GHIST_W-1:0] gi, input logic lp, input logic gp);
    logic [SLOT_W-1:0] s;
    s = pc[SLOT_W-1:0];
    m_hist[s] = {m_hist[s][LHIST_W-2:0], t};
    m_ghr     = {m_ghr[GHIST_W-2:0], t};
    m_lctr[li] = t ? ((m_lctr[li] < 7) ? m_lctr[li] + 1 : 7) : ((m_lctr[li] > 0) ? m_lctr[li] - 1 : 0);
    m_gctr[gi] = t ? ((m_gctr[gi] < 3) ? m_gctr[gi] + 1 : 3) : ((m_gctr[gi] > 0) ? m_gctr[gi] - 1 : 0);
    m_sel[gi]  = {gp == t, lp == t};
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid = 1'b0; rs_valid = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // compare outputs with model state captured before the edge
  task automatic lookup(input logic [PC_W-1:0] pc, input string req);
    logic [LHIST_W-1:0] li; logic [GHIST_W-1:0] gi; logic lp, gp, fin;
    li = m_hist[pc[SLOT_W-1:0]]; gi = m_ghr;
    lp = (m_lctr[li] >= 4); gp = (m_gctr[gi] >= 2);
    fin = (m_sel[gi] == 2'b01) ? lp : gp;
    lk_valid = 1'b1; lk_pc = pc;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "loc_idx", int'(lk_li), int'(li));
    chk(req, "glb_idx", int'(lk_gi), int'(gi));
    chk(req, "loc_pred", int'(lk_lp), int'(lp));
    chk(req, "glb_pred", int'(lk_gp), int'(gp));
    chk(req, "taken", int'(lk_taken), int'(fin));
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic t, input logic [LHIST_W-1:0] li,
                         input logic [GHIST_W-1:0] gi, input logic lp, input logic gp);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t; rs_li = li; rs_gi = gi; rs_lp = lp; rs_gp = gp;
    @(posedge clk); @(negedge clk);
    rs_valid = 1'b0;
    m_resolve(pc, t, li, gi, lp, gp);
  endtask

  task automatic steer_ghr(input logic [GHIST_W-1:0] target);
    for (int b = GHIST_W - 1; b >= 0; b--) resolve(16'h0044, target[b], 8'h20, 10'h200, 1'b0, 1'b0);
  endtask

  task automatic t_reset();  // R1
    do_reset();
    lookup(16'h1234, "R1");
    chk("R1", "taken_after_reset", int'(lk_taken), 1);
    chk("R1", "glb_idx_after_reset", int'(lk_gi), 0);
  endtask

  task automatic t_hold();  // R2
    do_reset();
    lookup(16'h0003, "R2");
    resolve(16'h0003, 1'b0, lk_li, lk_gi, lk_lp, lk_gp);
    lk_pc = 16'h0003;
    @(posedge clk); @(negedge clk);
    chk("R2", "hold_glb_idx", int'(lk_gi), 0);
    lookup(16'h0003, "R2");
    chk("R2", "new_glb_idx", int'(lk_gi), 0);
    chk("R2", "new_glb_pred", int'(lk_gp), 0);
  endtask

  task automatic t_local_hist();  // R3
    do_reset();
    resolve(16'h0011, 1'b1, 8'h00, 10'h000, 1'b1, 1'b1);
    resolve(16'h0011, 1'b0, 8'h01, 10'h001, 1'b1, 1'b1);
    resolve(16'h0011, 1'b1, 8'h02, 10'h002, 1'b1, 1'b1);
    resolve(16'h0112, 1'b1, 8'h00, 10'h005, 1'b1, 1'b1);  // other slot
    lookup(16'h0711, "R3");
    chk("R3", "slot_history", int'(lk_li), 5);
    chk("R5", "ghr_value", int'(lk_gi), 11);
  endtask

  task automatic t_sat_hi();  // R4 R6
    do_reset();
    for (int i = 0; i < 4; i++) resolve(16'h0001, 1'b1, 8'h09, 10'h003, 1'b1, 1'b1);
    steer_ghr(10'h003);
    lookup(16'h0055, "R6");
    chk("R6", "gctr_sat_hi_pred", int'(lk_gp), 1);
    resolve(16'h0033, 1'b1, 8'h20, 10'h200, 1'b0, 1'b0);
    resolve(16'h0033, 1'b0, 8'h20, 10'h200, 1'b0, 1'b0);
    resolve(16'h0033, 1'b0, 8'h20, 10'h200, 1'b0, 1'b0);
    resolve(16'h0033, 1'b1, 8'h20, 10'h200, 1'b0, 1'b0);
    lookup(16'h0033, "R4");
    chk("R4", "lctr_sat_hi_idx", int'(lk_li), 9);
    chk("R4", "lctr_sat_hi_pred", int'(lk_lp), 1);
  endtask

  task automatic t_sat_lo();  // R4
    do_reset();
    for (int i = 0; i < 5; i++) resolve(16'h0001, 1'b0, 8'h09, 10'h003, 1'b1, 1'b1);
    resolve(16'h0033, 1'b1, 8'h20, 10'h200, 1'b0, 1'b0);
    resolve(16'h0033, 1'b0, 8'h20, 10'h200, 1'b0, 1'b0);
    resolve(16'h0033, 1'b0, 8'h20, 10'h200, 1'b0, 1'b0);
    resolve(16'h0033, 1'b1, 8'h20, 10'h200, 1'b0, 1'b0);
    lookup(16'h0033, "R4");
    chk("R4", "lctr_sat_lo_pred", int'(lk_lp), 0);
  endtask

  task automatic t_choose_local();  // R7 R8
    do_reset();
    resolve(16'h0040, 1'b0, 8'h07, 10'h2A5, 1'b0, 1'b1);
    steer_ghr(10'h2A5);
    lookup(16'h0060, "R8");
    chk("R8", "local_selected", int'(lk_taken), 1);
    chk("R8", "global_differs", int'(lk_gp), 0);
  endtask

  task automatic t_choose_both();  // R7 R8
    do_reset();
    resolve(16'h0040, 1'b0, 8'h07, 10'h2A5, 1'b0, 1'b0);
    steer_ghr(10'h2A5);
    lookup(16'h0060, "R7");
    chk("R7", "both_right_uses_global", int'(lk_taken), 0);
    chk("R7", "local_differs", int'(lk_lp), 1);
  endtask

  task automatic t_idle_resolve();  // R9
    do_reset();
    rs_valid = 1'b0; rs_pc = 16'h0000; rs_taken = 1'b0; rs_li = 8'h00; rs_gi = 10'h000;
    rs_lp = 1'b1; rs_gp = 1'b0;
    repeat (3) @(negedge clk);
    lookup(16'h0000, "R9");
    chk("R9", "idle_glb_idx", int'(lk_gi), 0);
    chk("R9", "idle_taken", int'(lk_taken), 1);
  endtask

  task automatic t_same_edge();  // R10
    logic [GHIST_W-1:0] gi_before;
    do_reset();
    gi_before = m_ghr;
    lk_valid = 1'b1; lk_pc = 16'h0000;
    rs_valid = 1'b1; rs_pc = 16'h0000; rs_taken = 1'b0; rs_li = 8'h00; rs_gi = 10'h000;
    rs_lp = 1'b1; rs_gp = 1'b1;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
    chk("R10", "old_glb_idx", int'(lk_gi), int'(gi_before));
    chk("R10", "old_glb_pred", int'(lk_gp), 1);
    chk("R10", "old_loc_pred", int'(lk_lp), 1);
    m_resolve(16'h0000, 1'b0, 8'h00, 10'h000, 1'b1, 1'b1);
    lookup(16'h0000, "R10");
  endtask

  task automatic t_mixed();  // R3 R4 R5 R6 R7 R8
    logic [15:0] lfsr = 16'hACE1;
    logic [PC_W-1:0] pc;
    logic t;
    do_reset();
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = {8'h00, 4'h0, 2'b00, lfsr[1:0]} + 16'h0100;
      case (lfsr[1:0])
        2'd0: t = 1'b1;
        2'd1: t = n[0];
        2'd2: t = (n % 3) == 0;
        default: t = lfsr[7];
      endcase
      lookup(pc, "R8");
      resolve(pc, t, lk_li, lk_gi, lk_lp, lk_gp);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_hold();
        t_local_hist();
        t_sat_hi();
        t_sat_lo();
        t_choose_local();
        t_choose_both();
        t_idle_resolve();
        t_same_edge();
        t_mixed();
        done = 1'b1;
      end
      begin
        repeat (150000) @(posedge clk);
      end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule